// File: doc/BRIEF.md
# Preconditioned Three-Pattern Delay Test Sequencer

This controller paces a history-aware path delay test once the scan chain has been loaded. On a start request it first holds the path in its preconditioning state for a programmable number of clock cycles. This gives the floating bodies of the transistors time to settle into a static history. It then issues a single-cycle initialising step. Next it issues the launch, which returns the path to the preconditioning value. A programmable number of cycles after the launch, equal to the functional period under test, it fires the capture. One cycle after capture it reports completion.

Paths whose slowest edge is the second one after a quiet period ("stretching" paths) need all three steps. Paths whose slowest edge is the first one ("shrinking" paths) skip the initialising step. The long preconditioning hold is kept in both cases, and the launch then follows the hold directly, as in an ordinary two-pattern test. Each phase is signalled by a one-cycle strobe, and at most one strobe is high in any cycle. The hold length, the launch-to-capture distance and the mode are taken when the sequence starts.

Top module: `ptest_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer returns to idle after that edge: `busy`, `done` and all four phase strobes are low.
- R2: A `start` seen high at an edge while idle makes `busy` and `pre_stb` high in the following cycle. `pre_stb` lasts one cycle and marks the first of N hold cycles, where N is `precond_len`.
- R3: A `precond_len` of zero gives a hold of one cycle, and a `capture_gap` of zero gives a launch-to-capture distance of one cycle.
- R4: With `shrink_mode` low, `init_stb` is high for exactly one cycle, the cycle right after the last hold cycle, and `launch_stb` is high in the cycle after that.
- R5: `capt_stb` is high exactly G cycles after `launch_stb`, where G is `capture_gap`.
- R6: With `shrink_mode` high, `init_stb` never rises, and `launch_stb` is high in the cycle right after the last hold cycle.
- R7: `done` is high for one cycle, the cycle after `capt_stb`. `busy` is low from the cycle after `done`.
- R8: A `start` seen while `busy` is high has no effect: there is no second `pre_stb`, and the running sequence keeps its timing.
- R9: No more than one of `pre_stb`, `init_stb`, `launch_stb`, `capt_stb`, `done` is high in any cycle.
- R10: `precond_len`, `capture_gap` and `shrink_mode` are sampled only with an accepted `start`. Changing them during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a test sequence, taken only while idle |
| shrink_mode | input | 1 | 1: skip the initialising step (shrinking path); 0: full three-step test |
| precond_len | input | HOLD_W (16) | Preconditioning hold in cycles, 0 read as 1 |
| capture_gap | input | GAP_W (8) | Launch-to-capture distance in cycles, 0 read as 1 |
| busy | output | 1 | High from the cycle after an accepted start through the done cycle |
| pre_stb | output | 1 | First cycle of the preconditioning hold |
| init_stb | output | 1 | Initialising step, one cycle |
| launch_stb | output | 1 | Launch back to the preconditioning value |
| capt_stb | output | 1 | Capture pulse |
| done | output | 1 | Sequence complete, one cycle |

## Verification
Count cycles from the edge that takes `start` as cycle 0. With hold N and gap G, `pre_stb` is due in cycle 1. In the full mode `init_stb` is due in cycle N+1 and `launch_stb` in N+2. In the shrinking mode `launch_stb` is due in N+1. `capt_stb` is due G cycles after the launch, `done` one cycle after the capture, and `busy` falls one cycle after `done`. The bench samples every output on the falling edge of each cycle after the start edge. It records the cycle in which each strobe first appears and how many times each one appears, then compares them with these formulas. Start pulses and input changes made in the middle of a run use the same formulas, taken from the values present at the start edge.

// File: rtl/ptest_pkg.sv
// Shared types for the preconditioned delay test sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ptest_pkg;

    // Phases of one test sequence, in the order they normally run.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD   = 3'd1,
        ST_INIT   = 3'd2,
        ST_LAUNCH = 3'd3,
        ST_GAP    = 3'd4,
        ST_CAPT   = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/ptest_countdown.sv
// Loadable down-counter used for the hold and launch-to-capture windows.
// On load it takes load_val, reading zero as one. While run is high it
// counts down and stops at one. last is high while the count is one.
// Assumes: load and run are never high in the same cycle.
module ptest_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         last
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    // Count register: load with zero promoted to one, else decrement while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? ONE : load_val;
        end else if (run && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Terminal-count flag.
    always_comb begin
        last = (cnt_q == ONE);
    end

    // R3: a load never leaves the window at zero length.
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));

    // R3: a running window never drops below one.
    p_run_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && last) |=> last);

endmodule

// File: rtl/ptest_fsm.sv
// Phase controller for the delay test sequence. It accepts start only
// while idle and latches the mode at that moment. It walks through the
// hold, the optional initialising step, the launch, the gap and the
// capture, driving one strobe per phase.
// Assumes: hold_last and gap_last come from counters loaded on take.
module ptest_fsm
    import ptest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic shrink_in,
    input  logic hold_last,
    input  logic gap_last,
    output logic take,
    output logic hold_run,
    output logic gap_run,
    output logic busy,
    output logic pre_stb,
    output logic init_stb,
    output logic launch_stb,
    output logic capt_stb,
    output logic done
);

    seq_state_t state_q, state_d;
    logic       shrink_q;
    logic       first_q;

    // State, latched mode and first-hold-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shrink_q <= 1'b0;
            first_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= take;
            if (take) begin
                shrink_q <= shrink_in;
            end
        end
    end

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_HOLD;
            ST_HOLD:   if (hold_last) state_d = shrink_q ? ST_LAUNCH : ST_INIT;
            ST_INIT:   state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = gap_last ? ST_CAPT : ST_GAP;
            ST_GAP:    if (gap_last) state_d = ST_CAPT;
            ST_CAPT:   state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Counter controls and phase strobes decoded from the state.
    always_comb begin
        take       = (state_q == ST_IDLE) && start;
        hold_run   = (state_q == ST_HOLD);
        gap_run    = (state_q == ST_LAUNCH) || (state_q == ST_GAP);
        busy       = (state_q != ST_IDLE);
        pre_stb    = first_q;
        init_stb   = (state_q == ST_INIT);
        launch_stb = (state_q == ST_LAUNCH);
        capt_stb   = (state_q == ST_CAPT);
        done       = (state_q == ST_DONE);
    end

    // R1: reset forces idle.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (state_q == ST_IDLE) && !first_q);

    // R2: the hold-entry strobe lasts one cycle and comes with busy.
    p_pre_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |=> !pre_stb);
    p_pre_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |-> busy);

    // R4: the initialising step is one cycle and is followed by the launch.
    p_init_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> launch_stb && !init_stb);

    // R6: in shrinking mode the end of the hold leads straight to the launch.
    p_shrink_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_run && hold_last && shrink_q) |=> launch_stb);

    // R7: done follows capture by one cycle, then the sequencer is idle.
    p_done_after_capt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        capt_stb |=> done);
    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9: at most one phase strobe per cycle.
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_stb, init_stb, launch_stb, capt_stb, done}));

endmodule

// File: rtl/ptest_sequencer.sv
// Top of the preconditioned three-pattern delay test sequencer. It
// combines the phase controller with two window counters: one for the
// preconditioning hold and one for the launch-to-capture distance. Both
// counters are loaded from the port values when start is accepted.
// Assumes: scan loading is finished before start, and the strobes drive
// the scan-cell clocks elsewhere.
module ptest_sequencer #(
    parameter int HOLD_W = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shrink_mode,
    input  logic [HOLD_W-1:0] precond_len,
    input  logic [GAP_W-1:0]  capture_gap,
    output logic              busy,
    output logic              pre_stb,
    output logic              init_stb,
    output logic              launch_stb,
    output logic              capt_stb,
    output logic              done
);

    logic take;
    logic hold_run;
    logic gap_run;
    logic hold_last;
    logic gap_last;

    // Preconditioning hold window.
    ptest_countdown #(.W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_val (precond_len),
        .run      (hold_run),
        .last     (hold_last)
    );

    // Launch-to-capture window.
    ptest_countdown #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .load_val (capture_gap),
        .run      (gap_run),
        .last     (gap_last)
    );

    // Phase controller.
    ptest_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .shrink_in  (shrink_mode),
        .hold_last  (hold_last),
        .gap_last   (gap_last),
        .take       (take),
        .hold_run   (hold_run),
        .gap_run    (gap_run),
        .busy       (busy),
        .pre_stb    (pre_stb),
        .init_stb   (init_stb),
        .launch_stb (launch_stb),
        .capt_stb   (capt_stb),
        .done       (done)
    );

    // R7: done never appears without a capture in the cycle before.
    p_done_needs_capt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (!done || $past(capt_stb)));

endmodule

// File: tb/sim_ptest_sequencer.sv
// Directed bench for ptest_sequencer: one task per scenario.
module sim_ptest_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shrink_mode = 1'b0;
    logic [15:0] precond_len = '0;
    logic [7:0]  capture_gap = '0;
    logic        busy, pre_stb, init_stb, launch_stb, capt_stb, done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ptest_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .shrink_mode(shrink_mode),
        .precond_len(precond_len), .capture_gap(capture_gap),
        .busy(busy), .pre_stb(pre_stb), .init_stb(init_stb),
        .launch_stb(launch_stb), .capt_stb(capt_stb), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // R1: reset state, both at power-up and in the middle of a run.
    task automatic t_reset(input bit mid_run);
        if (mid_run) begin
            @(negedge clk);
            precond_len = 16'd20; capture_gap = 8'd2; shrink_mode = 1'b0; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (4) @(negedge clk);
            chk(busy == 1'b1, "R1 busy before mid-run reset", busy, 1);
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, pre_stb, init_stb, launch_stb, capt_stb, done} == 6'b0,
            "R1 outputs low in reset",
            int'({busy, pre_stb, init_stb, launch_stb, capt_stb, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", busy, 0);
    endtask

    // R2 R4 R5 R6 R7 R8 R9 R10: one sequence, timed from the start edge.
    task automatic t_run(input int len, input int gap, input bit shr, input bit poke);
        int n, g, e_init, e_launch, e_capt, e_done, e_idle;
        int pre_n, pre_at, init_n, init_at, lau_n, lau_at, cap_n, cap_at;
        int don_n, don_at, idle_at, multi, busy1;
        n = (len == 0) ? 1 : len;
        g = (gap == 0) ? 1 : gap;
        e_init   = shr ? -1 : n + 1;
        e_launch = shr ? n + 1 : n + 2;
        e_capt   = e_launch + g;
        e_done   = e_capt + 1;
        e_idle   = e_done + 1;
        pre_n = 0; pre_at = -1; init_n = 0; init_at = -1; lau_n = 0; lau_at = -1;
        cap_n = 0; cap_at = -1; don_n = 0; don_at = -1; idle_at = -1; multi = 0; busy1 = 0;
        @(negedge clk);
        precond_len = 16'(len); capture_gap = 8'(gap); shrink_mode = shr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= e_idle + 3; k++) begin
            if (k == 1) busy1 = busy;
            if (pre_stb)    begin pre_n++;  if (pre_at < 0)  pre_at = k;  end
            if (init_stb)   begin init_n++; if (init_at < 0) init_at = k; end
            if (launch_stb) begin lau_n++;  if (lau_at < 0)  lau_at = k;  end
            if (capt_stb)   begin cap_n++;  if (cap_at < 0)  cap_at = k;  end
            if (done)       begin don_n++;  if (don_at < 0)  don_at = k;  end
            if (!busy && idle_at < 0) idle_at = k;
            if (int'(pre_stb) + int'(init_stb) + int'(launch_stb) + int'(capt_stb) + int'(done) > 1)
                multi++;
            if (poke && k == 2) begin
                start = 1'b1; precond_len = 16'(len + 9);
                capture_gap = 8'(gap + 5); shrink_mode = ~shr;
            end
            if (poke && k == 3) start = 1'b0;
            if (poke && k == e_done - 1) start = 1'b1;
            if (poke && k == e_done) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(busy1 == 1, "R2 busy after start", busy1, 1);
        chk(pre_n == 1 && pre_at == 1, "R2 R8 single pre_stb in cycle 1", pre_at, 1);
        if (shr) chk(init_n == 0, "R6 no init_stb", init_n, 0);
        else     chk(init_n == 1 && init_at == e_init, "R4 init_stb cycle", init_at, e_init);
        chk(lau_n == 1 && lau_at == e_launch, shr ? "R6 launch cycle" : "R4 launch cycle",
            lau_at, e_launch);
        chk(cap_n == 1 && cap_at == e_capt, "R5 R10 capture cycle", cap_at, e_capt);
        chk(don_n == 1 && don_at == e_done, "R7 done cycle", don_at, e_done);
        chk(idle_at == e_idle, "R7 busy falls", idle_at, e_idle);
        chk(multi == 0, "R9 strobe overlap cycles", multi, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset(1'b0);                // R1
        t_run(5, 3, 1'b0, 1'b0);      // R2 R4 R5 R7 R9
        t_run(0, 0, 1'b0, 1'b0);      // R3 zero lengths
        t_run(4, 2, 1'b1, 1'b0);      // R6 shrinking
        t_run(0, 1, 1'b1, 1'b0);      // R3 R6
        t_run(300, 7, 1'b0, 1'b0);    // long hold
        t_run(6, 4, 1'b0, 1'b1);      // R8 R10 pokes while busy
        t_run(3, 2, 1'b1, 1'b1);      // R8 R10 in shrinking mode
        t_reset(1'b1);                // R1 mid-run
        t_run(2, 1, 1'b0, 1'b0);      // restart after reset
        summary();
        $finish;
    end

endmodule